// File: doc/BRIEF.md
# Gated Binary Up-Counter with Exclusive-OR Enables

This block is a parameterised binary up-counter (eight bits by default) that advances on the rising clock edge while a single internal "halt" flag is clear. The flag is a clocked register. On each edge it takes the exclusive-OR of two enable inputs. A mismatched pair of enables therefore stops the count one edge after it is sampled. A matched pair, either both high or both low, lets counting resume one edge later. While stopped, every output holds its value.

A start input clears the halt flag asynchronously. Counting is re-enabled at once, without waiting for an edge, and stays enabled whatever the enables do for as long as start is high. An asynchronous master reset zeroes the count and clears the flag. Each count bit is driven both true and inverted. There is no load or preset path, and the count wraps silently from its maximum to zero. A parameter selects how the next-count logic is built: a whole-word adder, or a chain of per-bit toggle conditions.

Top module: `xen_counter`

## Requirements
- R1: After master reset is released, the true bus reads 0, the inverted bus reads all ones, and the counter is enabled.
- R2: While enabled, the count increases by exactly one on every rising clock edge.
- R3: When exactly one of the two enables is high at an edge, the count still advances at that edge and then holds from the following edge onward.
- R4: When both enables are high at an edge, a halted counter advances again from the following edge onward.
- R5: When both enables are low at an edge, the counter is enabled from the following edge, the same as when both are high.
- R6: Raising start clears a halted state without a clock edge: the count does not change until the next edge, and it advances at that edge even if the enables differ.
- R7: While start is high, the counter advances on every edge whatever the enables are.
- R8: Asserting master reset zeroes the count immediately, without a clock edge, and reset takes priority over start on the count value.
- R9: The inverted bus is always the bitwise complement of the true bus.
- R10: The count wraps from its all-ones value to 0 with no other indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| mreset | input | 1 | Asynchronous master reset, active high |
| sen_a | input | 1 | First synchronous enable |
| sen_b | input | 1 | Second synchronous enable |
| astart | input | 1 | Asynchronous start, active high, overrides the enables |
| cnt_q | output | WIDTH | Count value, true polarity |
| cnt_qn | output | WIDTH | Count value, inverted |

## Verification
The clocked capture of the enable pair and the asynchronous start override can act in the same cycle. The bench provokes this by halting the counter with a mismatched enable pair. It then raises start between edges while the mismatch is still present, and keeps start high across several edges. The judgement is that the count does not move before the next edge, that it advances at that edge and every edge after it, and that once start falls the mismatch halts the count again one edge later. Reset and start are also held high together, and the count must stay at zero.

// File: rtl/xen_counter_pkg.sv
package xen_counter_pkg;

   typedef enum logic [0:0] {
      CS_ADDER  = 1'b0,
      CS_TOGGLE = 1'b1
   } count_style_e;

   localparam int unsigned XC_DEFAULT_W = 8;

endpackage

// File: rtl/xen_halt_ctl.sv
module xen_halt_ctl (
   input  logic clk,
   input  logic mreset,
   input  logic astart,
   input  logic en_a,
   input  logic en_b,
   output logic halt_q
);

   logic clr_async;
   assign clr_async = mreset | astart;

   always_ff @(posedge clk or posedge clr_async) begin
      if (clr_async) halt_q <= 1'b0;
      else           halt_q <= en_a ^ en_b;
   end

   // R3 R4 R5
   property halt_capture_p;
      @(posedge clk) disable iff (mreset || astart)
         !astart |=> (halt_q == $past(en_a ^ en_b));
   endproperty
   halt_capture_chk: assert property (halt_capture_p);

   // R7
   property start_override_p;
      @(posedge clk) disable iff (mreset)
         astart |-> !halt_q;
   endproperty
   start_override_chk: assert property (start_override_p);

endmodule

// File: rtl/xen_count_core.sv
module xen_count_core
   import xen_counter_pkg::*;
#(
   parameter int unsigned  WIDTH = XC_DEFAULT_W,
   parameter count_style_e STYLE = CS_ADDER
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             adv,
   output logic [WIDTH-1:0] cnt
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   initial begin
      if (WIDTH < 2) $error("xen_count_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] nxt;

   generate
      if (STYLE == CS_ADDER) begin : g_adder
         assign nxt = cnt + ONE;
      end else begin : g_toggle
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign nxt[i]     = cnt[i] ^ carry[i];
            assign carry[i+1] = carry[i] & cnt[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset)   cnt <= '0;
      else if (adv) cnt <= nxt;
   end

   // R2 R10
   property step_p;
      @(posedge clk) disable iff (mreset)
         adv |=> (cnt == $past(cnt) + ONE);
   endproperty
   step_chk: assert property (step_p);

   // R3
   property hold_p;
      @(posedge clk) disable iff (mreset)
         !adv |=> $stable(cnt);
   endproperty
   hold_chk: assert property (hold_p);

   // R8
   property reset_zero_p;
      @(posedge clk) mreset |-> (cnt == '0);
   endproperty
   reset_zero_chk: assert property (reset_zero_p);

endmodule

// File: rtl/xen_comp_drv.sv
module xen_comp_drv #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q_t,
   output logic [WIDTH-1:0] q_n
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pair
         assign q_t[i] = din[i];
         assign q_n[i] = ~din[i];
      end
   endgenerate

endmodule

// File: rtl/xen_counter.sv
module xen_counter
   import xen_counter_pkg::*;
#(
   parameter int unsigned  WIDTH = XC_DEFAULT_W,
   parameter count_style_e STYLE = CS_ADDER
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             sen_a,
   input  logic             sen_b,
   input  logic             astart,
   output logic [WIDTH-1:0] cnt_q,
   output logic [WIDTH-1:0] cnt_qn
);

   logic             halt_q;
   logic [WIDTH-1:0] cnt_w;

   xen_halt_ctl u_ctl (
      .clk    (clk),
      .mreset (mreset),
      .astart (astart),
      .en_a   (sen_a),
      .en_b   (sen_b),
      .halt_q (halt_q)
   );

   xen_count_core #(.WIDTH(WIDTH), .STYLE(STYLE)) u_core (
      .clk    (clk),
      .mreset (mreset),
      .adv    (!halt_q),
      .cnt    (cnt_w)
   );

   xen_comp_drv #(.WIDTH(WIDTH)) u_drv (
      .din (cnt_w),
      .q_t (cnt_q),
      .q_n (cnt_qn)
   );

   // R9
   property comp_pair_p;
      @(posedge clk) (cnt_qn ^ cnt_q) == '1;
   endproperty
   comp_pair_chk: assert property (comp_pair_p);

endmodule

// File: tb/xen_counter_test.sv
`timescale 1ns/1ps
module xen_counter_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         mreset = 1'b1;
   logic         sen_a = 1'b0;
   logic         sen_b = 1'b0;
   logic         astart = 1'b0;
   logic [W-1:0] cnt_q, cnt_qn;

   int n_tot = 0;
   int n_bad = 0;
   logic [W-1:0] m_cnt = '0;
   logic         m_halt = 1'b0;

   always #2.5 clk = ~clk;

   xen_counter #(.WIDTH(W)) uut (
      .clk(clk), .mreset(mreset), .sen_a(sen_a), .sen_b(sen_b),
      .astart(astart), .cnt_q(cnt_q), .cnt_qn(cnt_qn)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock: model follows the requirements, then sample at the falling edge
   task automatic cyc(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         if (mreset)      m_cnt = '0;
         else if (!m_halt) m_cnt = m_cnt + 1'b1;
         m_halt = (mreset || astart) ? 1'b0 : (sen_a ^ sen_b);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      mreset = 1'b1; m_cnt = '0; m_halt = 1'b0;
      cyc(2);
      mreset = 1'b0;
      chk("R1 count", cnt_q, 8'h00);
      chk("R1 inverted", cnt_qn, 8'hFF);
      cyc(1);
      chk("R1 enabled after reset", cnt_q, 8'h01);
   endtask

   task automatic t_count();
      cyc(5);
      chk("R2 count up", cnt_q, m_cnt);
      chk("R2 value", cnt_q, 8'h06);
      chk("R9 complement", cnt_qn, ~m_cnt);
   endtask

   task automatic t_one_enable();
      logic [W-1:0] base;
      base = cnt_q;
      sen_a = 1'b1;
      cyc(1);
      chk("R3 advance at sample edge", cnt_q, base + 8'd1);
      cyc(3);
      chk("R3 held", cnt_q, base + 8'd1);
      chk("R3 model", cnt_q, m_cnt);
      sen_b = 1'b1;
      cyc(1);
      chk("R4 still held at sample edge", cnt_q, base + 8'd1);
      cyc(2);
      chk("R4 resumed", cnt_q, base + 8'd3);
   endtask

   task automatic t_no_enable();
      logic [W-1:0] base;
      sen_a = 1'b0; sen_b = 1'b1;
      cyc(2);
      base = cnt_q;
      sen_b = 1'b0;
      cyc(1);
      chk("R5 held at sample edge", cnt_q, base);
      cyc(3);
      chk("R5 counting with both low", cnt_q, base + 8'd3);
   endtask

   task automatic t_start();
      logic [W-1:0] base;
      sen_a = 1'b1; sen_b = 1'b0;
      cyc(3);
      base = cnt_q;
      #1 astart = 1'b1; m_halt = 1'b0;
      #0.5;
      chk("R6 no change before edge", cnt_q, base);
      cyc(1);
      chk("R6 advance at first edge", cnt_q, base + 8'd1);
      cyc(3);
      chk("R7 counting under start", cnt_q, base + 8'd4);
      sen_a = 1'b0; sen_b = 1'b1;
      cyc(2);
      chk("R7 enables ignored", cnt_q, base + 8'd6);
      astart = 1'b0;
      cyc(1);
      chk("R3 after start falls", cnt_q, base + 8'd7);
      cyc(2);
      chk("R3 halted after start", cnt_q, base + 8'd7);
      sen_a = 1'b0; sen_b = 1'b0;
      cyc(2);
   endtask

   task automatic t_async_reset();
      cyc(1);
      mreset = 1'b1;
      #1;
      chk("R8 async clear", cnt_q, 8'h00);
      astart = 1'b1;
      cyc(3);
      chk("R8 reset over start", cnt_q, 8'h00);
      mreset = 1'b0;
      m_cnt = '0;
      cyc(2);
      chk("R7 start after reset", cnt_q, 8'h02);
      astart = 1'b0;
      cyc(1);
   endtask

   task automatic t_wrap();
      mreset = 1'b1; m_cnt = '0; m_halt = 1'b0;
      cyc(1);
      mreset = 1'b0;
      cyc(255);
      chk("R10 top value", cnt_q, 8'hFF);
      chk("R9 top inverted", cnt_qn, 8'h00);
      cyc(1);
      chk("R10 wrap to zero", cnt_q, 8'h00);
      chk("R9 wrap inverted", cnt_qn, 8'hFF);
   endtask

   initial begin : watchdog
      #200000;
      n_tot++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_count();
      t_one_enable();
      t_no_enable();
      t_start();
      t_async_reset();
      t_wrap();
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end

endmodule